// File: doc/BRIEF.md
# Ping-Pong Buffer Address Arbiter

This block steers a pair of external RAM buffers that take turns. While one buffer is being filled from an input stream, the other is being read out to a downstream consumer. When the buffer being filled is complete and the other has been read out, the two swap roles. The block issues the shared RAM address, a write strobe for the fill side and a read strobe for the drain side. It also reports which buffer is currently the fill target and which buffers hold data. The RAM pin timing is handled outside.

There is only one address counter. A single spare register holds the position of whichever side is paused, and the two are exchanged whenever control passes from one side to the other. Incoming data always wins the counter. When input runs dry, draining continues on its own. When input comes back, draining stops and filling resumes from its saved position. Filling runs alone until it reaches the address where draining stopped, and from then on both sides move on one shared address. A buffer with no data is never read.

Top module: `pp_arbiter`

## Requirements
- R1: Reset (active-low `rstN`) clears both buffers to empty (`bufFull` = 2'b00), selects buffer 0 for filling (`fillSel` = 0), clears the address and the save register to 0, and asserts neither strobe.
- R2: While `inAvail` is 1, the fill buffer is not full, and the fill side owns the counter, `wrStb` is 1 in every cycle and `ramAddr` rises by one per cycle, starting at 0 after reset or after a swap.
- R3: A write at the last address (2**AW-1) sets the fill buffer's bit in `bufFull` (bit index = buffer number). No write is issued to a buffer whose bit is set.
- R4: When the fill buffer is full and the drain buffer (index `~fillSel`) is empty, the next cycle is a swap cycle with no strobes. After it, `fillSel` is inverted and `ramAddr` is 0.
- R5: When both sides can move and the fill address equals the paused drain address, `wrStb` and `rdStb` are both 1 in the same cycle on the same `ramAddr`, and both positions advance together.
- R6: If `inAvail` is 0 while the fill side owns the counter and the drain buffer holds data, one handover cycle with no strobes follows, in which the counter does not move. After it, draining proceeds alone from the current address, one read per cycle.
- R7: If `inAvail` returns while the drain side owns the counter, one handover cycle with no strobes follows. After it, filling resumes at the saved fill address, with `rdStb` held at 0 until the fill address reaches the saved drain address.
- R8: `rdStb` is never 1 while the drain buffer is empty. With no input and nothing to drain, both strobes stay 0 and the address holds.
- R9: A read at the last address clears the drain buffer's bit in `bufFull`.
- R10: Input has priority: in any non-swap cycle with `inAvail` = 1 and a non-full fill buffer, `rdStb` is 1 only if `wrStb` is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inAvail | input | 1 | A word is available on the input stream this cycle |
| ramAddr | output | AW | Shared address for both buffers |
| fillSel | output | 1 | Index of the buffer being filled; the other one is drained |
| wrStb | output | 1 | Write the input word into buffer `fillSel` at `ramAddr` |
| rdStb | output | 1 | Read buffer `~fillSel` at `ramAddr` to the output |
| bufFull | output | 2 | Per-buffer data-held flag; 0 means empty |

## Verification
The bench aims at three corner cases.

The first is the catch-up after a pause. A design that lets draining resume before the fill address meets the saved drain address would read at the wrong address, or would move both sides while they are out of step.

The second is the handover cycles. A design that moves the counter during an exchange would skip or repeat an address on the side that resumes.

The third is the end of each buffer. A design that gets this wrong would swap early, write into a full buffer, or keep reading a buffer that has already been emptied, which would send garbage words downstream.

// File: rtl/pp_arb_pkg.sv
package pp_arb_pkg;
  // strobes from the control FSM to the address datapath
  typedef struct packed {
    logic clr;      // both positions to zero (buffer swap)
    logic xchg;     // exchange counter and save register
    logic incCnt;   // advance the active position
    logic incSave;  // advance the paused position (lockstep)
  } ctrlStrb_t;
endpackage

// File: rtl/pp_addr_path.sv
module pp_addr_path
  import pp_arb_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrb_t     strb,
  output logic [AW-1:0] addr,
  output logic          addrEqSave,
  output logic          addrAtEnd
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [AW-1:0] cnt;
  logic [AW-1:0] saveReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      saveReg <= '0;
    end else if (strb.clr) begin
      cnt     <= '0;
      saveReg <= '0;
    end else if (strb.xchg) begin
      cnt     <= saveReg;
      saveReg <= cnt;
    end else begin
      if (strb.incCnt)  cnt     <= cnt + 1'b1;
      if (strb.incSave) saveReg <= saveReg + 1'b1;
    end
  end

  assign addr       = cnt;
  assign addrEqSave = (cnt == saveReg);
  assign addrAtEnd  = (cnt == LAST);

  // R6 / R7: handover swaps the two positions and does not count
  p_xchg_swap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xchg && !strb.clr) |=> (cnt == $past(saveReg)) && (saveReg == $past(cnt)));

  // R4: a swap restarts both positions at zero
  p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cnt == '0) && (saveReg == '0));

  // R2: a plain advance moves the address by exactly one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCnt && !strb.clr && !strb.xchg) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inAvail,
  input  logic       addrEqSave,
  input  logic       addrAtEnd,
  output ctrlStrb_t  strb,
  output logic       fillSel,
  output logic       wrStb,
  output logic       rdStb,
  output logic [1:0] bufFull
);
  typedef enum logic {OWN_FILL, OWN_DRAIN} owner_e;

  owner_e     owner;
  logic [1:0] full;
  logic       selQ;
  logic       fillCan, drainCan, swapNow;

  assign fillCan  = inAvail && !full[selQ];
  assign drainCan = full[~selQ];
  assign swapNow  = full[selQ] && !full[~selQ];

  always_comb begin
    strb  = '0;
    wrStb = 1'b0;
    rdStb = 1'b0;
    if (swapNow) begin
      strb.clr = 1'b1;
    end else if (fillCan) begin
      if (owner == OWN_DRAIN) begin
        strb.xchg = 1'b1;
      end else begin
        wrStb       = 1'b1;
        strb.incCnt = 1'b1;
        if (drainCan && addrEqSave) begin
          rdStb        = 1'b1;
          strb.incSave = 1'b1;
        end
      end
    end else if (drainCan) begin
      if (owner == OWN_FILL) begin
        strb.xchg = 1'b1;
      end else begin
        rdStb       = 1'b1;
        strb.incCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner <= OWN_FILL;
      full  <= 2'b00;
      selQ  <= 1'b0;
    end else if (strb.clr) begin
      owner <= OWN_FILL;
      selQ  <= ~selQ;
    end else begin
      if (strb.xchg)
        owner <= (owner == OWN_FILL) ? OWN_DRAIN : OWN_FILL;
      if (wrStb && addrAtEnd) full[selQ]  <= 1'b1;
      if (rdStb && addrAtEnd) full[~selQ] <= 1'b0;
    end
  end

  assign fillSel = selQ;
  assign bufFull = full;

  p_rd_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |-> bufFull[~fillSel]);

  p_wr_notfull_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> !bufFull[fillSel]);

  p_swap_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fillSel != $past(fillSel)) |-> ($past(bufFull) == (2'b01 << $past(fillSel))));

  p_xchg_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.xchg |-> (!wrStb && !rdStb));

  p_input_prio_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inAvail && !bufFull[fillSel] && !strb.clr) |-> (!rdStb || wrStb));
endmodule

// File: rtl/pp_arbiter.sv
module pp_arbiter
  import pp_arb_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inAvail,
  output logic [AW-1:0] ramAddr,
  output logic          fillSel,
  output logic          wrStb,
  output logic          rdStb,
  output logic [1:0]    bufFull
);
  ctrlStrb_t strb;
  logic      addrEqSave;
  logic      addrAtEnd;

  pp_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inAvail    (inAvail),
    .addrEqSave (addrEqSave),
    .addrAtEnd  (addrAtEnd),
    .strb       (strb),
    .fillSel    (fillSel),
    .wrStb      (wrStb),
    .rdStb      (rdStb),
    .bufFull    (bufFull)
  );

  pp_addr_path #(.AW(AW)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addr       (ramAddr),
    .addrEqSave (addrEqSave),
    .addrAtEnd  (addrAtEnd)
  );
endmodule

// File: tb/test_pp_arbiter.sv
module test_pp_arbiter;
  localparam int AW = 3;
  localparam int NV = 36;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inAvail = 1'b0;
  logic [AW-1:0] ramAddr;
  logic          fillSel, wrStb, rdStb;
  logic [1:0]    bufFull;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pp_arbiter #(.AW(AW)) i_pp_arbiter (
    .clk(clk), .rstN(rstN), .inAvail(inAvail), .ramAddr(ramAddr),
    .fillSel(fillSel), .wrStb(wrStb), .rdStb(rdStb), .bufFull(bufFull)
  );

  // {inAvail, wrStb, rdStb, ramAddr[2:0], fillSel, bufFull[1:0]}
  localparam logic [8:0] VEC [NV] = '{
    9'b110_000_0_00, 9'b110_001_0_00, 9'b110_010_0_00, 9'b110_011_0_00, // R2 fill A
    9'b110_100_0_00, 9'b110_101_0_00, 9'b110_110_0_00, 9'b110_111_0_00, // R3 last write
    9'b100_000_0_01,                                                     // R4 swap
    9'b111_000_1_01, 9'b111_001_1_01, 9'b111_010_1_01,                   // R5 lockstep
    9'b000_011_1_01,                                                     // R6 handover
    9'b001_011_1_01, 9'b001_100_1_01,                                    // R6 drain alone
    9'b100_101_1_01,                                                     // R10 input takes counter
    9'b110_011_1_01, 9'b110_100_1_01,                                    // R7 catch-up
    9'b111_101_1_01, 9'b111_110_1_01,                                    // R5 rejoined
    9'b111_111_1_01,                                                     // R9 both wrap
    9'b100_000_1_10,                                                     // R4 swap back
    9'b000_000_0_10,                                                     // R6 handover
    9'b001_000_0_10, 9'b001_001_0_10, 9'b001_010_0_10, 9'b001_011_0_10,
    9'b001_100_0_10, 9'b001_101_0_10, 9'b001_110_0_10,                   // R6 drain B
    9'b001_111_0_10,                                                     // R9 drain empties
    9'b000_000_0_00, 9'b000_000_0_00,                                    // R8 idle
    9'b100_000_0_00,                                                     // R10 handover to fill
    9'b110_000_0_00, 9'b110_001_0_00                                     // R2 fill again
  };

  function automatic string reqOf(int i);
    if (i < 7)  return "R2";
    if (i == 7) return "R3";
    if (i == 8 || i == 21) return "R4";
    if (i < 12 || i == 18 || i == 19) return "R5";
    if (i < 15 || (i >= 22 && i < 30)) return "R6";
    if (i == 15 || i == 33) return "R10";
    if (i < 18) return "R7";
    if (i == 20 || i == 30) return "R9";
    if (i < 33) return "R8";
    return "R2";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: {wr,rd,addr,sel,full} actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", {wrStb, rdStb, ramAddr, fillSel, bufFull}, 8'b00_000_0_00); // R1 during reset
    rstN = 1'b1;
    #1;
    check("R1", {wrStb, rdStb, ramAddr, fillSel, bufFull}, 8'b00_000_0_00);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      inAvail = VEC[i][8];
      #1;
      check(reqOf(i), {wrStb, rdStb, ramAddr, fillSel, bufFull}, VEC[i][7:0]);
    end
    // R1: reset mid-run with input active returns to the idle start state
    @(negedge clk);
    inAvail = 1'b1;
    rstN = 1'b0;
    @(negedge clk);
    inAvail = 1'b0;
    #1;
    check("R1", {wrStb, rdStb, ramAddr, fillSel, bufFull}, 8'b00_000_0_00);
    rstN = 1'b1;
    // R8: nothing to drain and no input keeps strobes low and address held
    repeat (3) @(negedge clk);
    #1;
    check("R8", {wrStb, rdStb, ramAddr, fillSel, bufFull}, 8'b00_000_0_00);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule